// File: doc/BRIEF.md
# Strobe-Encoded Setting Decoder

This block turns front-panel selections into settings. Each selection is made by wiring one of the scanned digit strobes back onto a setting pin. The scanner reports the current digit slot and raises a one-cycle sample strobe in the settled second half of that slot. The decoder records which slots showed an asserted level on each setting pin. From that record it builds the measurement function, the gating range, a set of control flags and an external decimal-point mask. These are passed to the measurement sequencer and the display scanner.

The function and range pins carry one strobe at a time. The control pin may carry several strobes at once, and each one sets its own flag. A scan frame completes at the sample of the last slot in the descending scan, which is digit D1, index 0. Results are applied only then. A function or range selection that is missing, ambiguous or unassigned leaves the previous value in place.

The display-off state combines a control strobe with the hold input. While it is in effect, frame results are ignored. Releasing hold ends it and signals a restart to the sequencer. A single-cycle change pulse tells the sequencer to abandon a measurement whenever the function or range setting moves.

Top module: `strobe_setting_decoder`

## Requirements
- R1: Pin levels affect the decoder only in cycles where `sample_i` is high. Levels present in the other cycles of a slot are never recorded.
- R2: With `ACTIVE_LOW`=0 a setting pin is asserted when high. With `ACTIVE_LOW`=1 it is asserted when low, and identical selections give identical outputs.
- R3: After reset, `func_o`=0, `range_o`=0, `ctl_flags_o`=0, `dp_mask_o`=0, `disp_off_o`=0 and `chg_o`=0. The decoded outputs change only in the cycle after a sample at digit index 0, which ends a frame.
- R4: The function code comes from the single digit seen on `fn_pin`: D1 gives frequency (0), D8 gives period (1), D2 gives ratio (2), D5 gives time interval (3), D4 gives unit count (4), and D3 gives oscillator self-test (5). Digit Dn is index n-1.
- R5: The range code comes from the single digit seen on `rng_pin`: D1 gives 0, D2 gives 1, D3 gives 2, D4 gives 3, and D5 gives external range (4).
- R6: If a frame shows no strobe, more than one strobe, or only an unassigned digit on the function pin (D6, D7) or the range pin (D6, D7, D8), that register keeps its value.
- R7: Each applied frame loads `ctl_flags_o` from every strobe seen on `ctl_pin`: bit0 for D1 (external oscillator), bit1 for D2 (1 MHz timebase), bit2 for D3 (external decimal point enable) and bit3 for D8 (display test).
- R8: `disp_off_o` sets when an applied frame shows D4 on `ctl_pin` while `hold_i` is high. It stays set while `hold_i` is high and clears in the cycle after `hold_i` is seen low. D4 with `hold_i` low does not set it.
- R9: Frame results are discarded while display off is in effect. The first frame completed after reset, and the first frame completed after display off ends, are also discarded, because either may be partial.
- R10: `chg_o` is high for exactly the cycle after an edge at which `func_o` or `range_o` changed, or at which display off ended. An applied frame that repeats the current codes gives no pulse.
- R11: Each applied frame loads `dp_mask_o` bit n-1 high when digit Dn was seen on `xdp_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_pin | input | 1 | Function selection pin |
| rng_pin | input | 1 | Range selection pin |
| ctl_pin | input | 1 | Control selection pin (may carry several strobes) |
| xdp_pin | input | 1 | External decimal-point pin |
| hold_i | input | 1 | Hold input, active high, not multiplexed |
| digit_i | input | $clog2(NDIG) | Index of the digit slot being scanned (0 = D1) |
| sample_i | input | 1 | One-cycle sample strobe in the second half of a slot |
| func_o | output | 3 | Decoded function code |
| range_o | output | 3 | Decoded range code |
| ctl_flags_o | output | 4 | Control flags (see R7) |
| disp_off_o | output | 1 | Display off in effect |
| dp_mask_o | output | NDIG | External decimal-point digit mask |
| chg_o | output | 1 | Setting-change / restart pulse |

## Verification
The hardest situation to reach is the display-off round trip. The stimulus must first complete a frame with D4 on the control pin while hold is high. It must then complete further frames while display off stays in force. After releasing hold it must finish one frame that is discarded before a changed function is accepted. The bench scripts that exact sequence. Every slot is driven as two noise cycles with the inverted selection, followed by the sample cycle, so any leak of unsampled levels turns into a multiple-strobe frame. A second instance built with inverted polarity receives the complemented pins, and both instances are compared against a behavioural model on every clock.

// File: rtl/strobe_setting_pkg.sv
package strobe_setting_pkg;

  typedef enum logic [2:0] {
    FN_FREQ   = 3'd0,
    FN_PERIOD = 3'd1,
    FN_RATIO  = 3'd2,
    FN_TINT   = 3'd3,
    FN_UNIT   = 3'd4,
    FN_OSC    = 3'd5
  } fn_code_e;

  typedef enum logic [2:0] {
    RG_X1   = 3'd0,
    RG_X10  = 3'd1,
    RG_X100 = 3'd2,
    RG_X1K  = 3'd3,
    RG_EXT  = 3'd4
  } rg_code_e;

  // bit3 = digit is assigned, bits2:0 = code
  function automatic logic [3:0] fn_lookup(input int dig);
    case (dig)
      0:       fn_lookup = {1'b1, FN_FREQ};
      1:       fn_lookup = {1'b1, FN_RATIO};
      2:       fn_lookup = {1'b1, FN_OSC};
      3:       fn_lookup = {1'b1, FN_UNIT};
      4:       fn_lookup = {1'b1, FN_TINT};
      7:       fn_lookup = {1'b1, FN_PERIOD};
      default: fn_lookup = 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] rg_lookup(input int dig);
    case (dig)
      0:       rg_lookup = {1'b1, RG_X1};
      1:       rg_lookup = {1'b1, RG_X10};
      2:       rg_lookup = {1'b1, RG_X100};
      3:       rg_lookup = {1'b1, RG_X1K};
      4:       rg_lookup = {1'b1, RG_EXT};
      default: rg_lookup = 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
  parameter int NDIG       = 8,
  parameter int NPIN       = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int DW        = $clog2(NDIG)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NPIN-1:0]                 pins_i,
  input  logic                            sample_i,
  input  logic [DW-1:0]                   digit_i,
  output logic                            frame_end_o,
  output logic [NPIN-1:0][NDIG-1:0]       seen_o
);

  logic [NPIN-1:0]            act;
  logic [NDIG-1:0]            slot_hot;
  logic [NPIN-1:0][NDIG-1:0]  acc_q;

  assign slot_hot    = sample_i ? (NDIG'(1) << digit_i) : '0;
  assign frame_end_o = sample_i && (digit_i == '0);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    if (ACTIVE_LOW) begin : g_lo
      assign act[p] = ~pins_i[p];
    end else begin : g_hi
      assign act[p] = pins_i[p];
    end
    assign seen_o[p] = acc_q[p] | (act[p] ? slot_hot : '0);
  end

  always_ff @(posedge clk) begin
    if (rst)              acc_q <= '0;
    else if (frame_end_o) acc_q <= '0;
    else                  acc_q <= seen_o;
  end

  // R1: levels outside the sample cycle never enter the record
  a_r1_idle_no_capture: assert property (@(posedge clk) disable iff (rst)
    !sample_i |=> $stable(acc_q));

endmodule

// File: rtl/strobe_pick.sv
module strobe_pick #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask_i,
  output logic          single_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign single_o = ($countones(mask_i) == 1);

endmodule

// File: rtl/strobe_setting_decoder.sv
module strobe_setting_decoder
  import strobe_setting_pkg::*;
#(
  parameter int NDIG       = 8,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int DW        = $clog2(NDIG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fn_pin,
  input  logic            rng_pin,
  input  logic            ctl_pin,
  input  logic            xdp_pin,
  input  logic            hold_i,
  input  logic [DW-1:0]   digit_i,
  input  logic            sample_i,
  output logic [2:0]      func_o,
  output logic [2:0]      range_o,
  output logic [3:0]      ctl_flags_o,
  output logic            disp_off_o,
  output logic [NDIG-1:0] dp_mask_o,
  output logic            chg_o
);

  localparam int PIN_FN  = 0;
  localparam int PIN_RG  = 1;
  localparam int PIN_CT  = 2;
  localparam int PIN_DP  = 3;
  localparam int NPIN    = 4;
  localparam int DIG_OFF = 3;
  localparam int DIG_TST = NDIG - 1;

  logic                      frame_end;
  logic [NPIN-1:0][NDIG-1:0] seen;
  logic                      fn_single, rg_single;
  logic [DW-1:0]             fn_idx, rg_idx;
  logic [3:0]                fn_lu, rg_lu;
  logic                      fn_take, rg_take, apply;
  logic [NDIG-1:0]           ctl_seen;
  logic [3:0]                ctl_next;
  logic                      off_exit;

  logic [2:0]      func_q, range_q;
  logic [3:0]      ctl_q;
  logic            disp_off_q, arm_q, chg_q;
  logic [NDIG-1:0] dp_q;

  strobe_capture #(.NDIG(NDIG), .NPIN(NPIN), .ACTIVE_LOW(ACTIVE_LOW)) u_cap (
    .clk         (clk),
    .rst         (rst),
    .pins_i      ({xdp_pin, ctl_pin, rng_pin, fn_pin}),
    .sample_i    (sample_i),
    .digit_i     (digit_i),
    .frame_end_o (frame_end),
    .seen_o      (seen)
  );

  strobe_pick #(.N(NDIG)) u_fn_pick (
    .mask_i   (seen[PIN_FN]),
    .single_o (fn_single),
    .idx_o    (fn_idx)
  );

  strobe_pick #(.N(NDIG)) u_rg_pick (
    .mask_i   (seen[PIN_RG]),
    .single_o (rg_single),
    .idx_o    (rg_idx)
  );

  assign fn_lu    = fn_lookup(int'(fn_idx));
  assign rg_lu    = rg_lookup(int'(rg_idx));
  assign apply    = frame_end && arm_q && !disp_off_q;
  assign fn_take  = apply && fn_single && fn_lu[3];
  assign rg_take  = apply && rg_single && rg_lu[3];
  assign ctl_seen = seen[PIN_CT];
  assign ctl_next = {ctl_seen[DIG_TST], ctl_seen[2], ctl_seen[1], ctl_seen[0]};
  assign off_exit = disp_off_q && !hold_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q     <= FN_FREQ;
      range_q    <= RG_X1;
      ctl_q      <= '0;
      dp_q       <= '0;
      disp_off_q <= 1'b0;
      arm_q      <= 1'b0;
      chg_q      <= 1'b0;
    end else begin
      if (fn_take) func_q  <= fn_lu[2:0];
      if (rg_take) range_q <= rg_lu[2:0];
      if (apply) begin
        ctl_q <= ctl_next;
        dp_q  <= seen[PIN_DP];
      end
      if (off_exit)
        disp_off_q <= 1'b0;
      else if (apply && ctl_seen[DIG_OFF] && hold_i)
        disp_off_q <= 1'b1;
      if (disp_off_q)     arm_q <= 1'b0;
      else if (frame_end) arm_q <= 1'b1;
      chg_q <= off_exit
             || (fn_take && (fn_lu[2:0] != func_q))
             || (rg_take && (rg_lu[2:0] != range_q));
    end
  end

  assign func_o      = func_q;
  assign range_o     = range_q;
  assign ctl_flags_o = ctl_q;
  assign disp_off_o  = disp_off_q;
  assign dp_mask_o   = dp_q;
  assign chg_o       = chg_q;

  // R3: settings move only after a frame-ending sample
  a_r3_frame_gated: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(func_q) && $stable(range_q) && $stable(ctl_q)));

  // R9: settings frozen while display off is in effect
  a_r9_frozen_off: assert property (@(posedge clk) disable iff (rst)
    disp_off_q |=> ($stable(func_q) && $stable(range_q) && $stable(dp_q)));

  // R10: every function or range movement is flagged
  a_r10_change_flagged: assert property (@(posedge clk) disable iff (rst)
    (!$stable(func_q) || !$stable(range_q)) |-> chg_q);

  // R8: releasing hold ends display off on the next edge
  a_r8_hold_release: assert property (@(posedge clk) disable iff (rst)
    (disp_off_q && !hold_i) |=> (!disp_off_q && chg_q));

endmodule

// File: tb/strobe_setting_decoder_tb.sv
module strobe_setting_decoder_tb;

  localparam int NDIG = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fn_p = 0, rg_p = 0, ct_p = 0, dp_p = 0, hold = 0, smp = 0;
  logic [2:0] dig = '0;

  logic [2:0] h_func, h_rng, l_func, l_rng;
  logic [3:0] h_ctl, l_ctl;
  logic       h_off, l_off, h_chg, l_chg;
  logic [7:0] h_dp, l_dp;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  strobe_setting_decoder #(.NDIG(NDIG), .ACTIVE_LOW(1'b0)) u_dut (
    .clk(clk), .rst(rst), .fn_pin(fn_p), .rng_pin(rg_p), .ctl_pin(ct_p),
    .xdp_pin(dp_p), .hold_i(hold), .digit_i(dig), .sample_i(smp),
    .func_o(h_func), .range_o(h_rng), .ctl_flags_o(h_ctl),
    .disp_off_o(h_off), .dp_mask_o(h_dp), .chg_o(h_chg));

  strobe_setting_decoder #(.NDIG(NDIG), .ACTIVE_LOW(1'b1)) u_dut_lo (
    .clk(clk), .rst(rst), .fn_pin(~fn_p), .rng_pin(~rg_p), .ctl_pin(~ct_p),
    .xdp_pin(~dp_p), .hold_i(hold), .digit_i(dig), .sample_i(smp),
    .func_o(l_func), .range_o(l_rng), .ctl_flags_o(l_ctl),
    .disp_off_o(l_off), .dp_mask_o(l_dp), .chg_o(l_chg));

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_func, m_rng, m_ctl, m_dp;
  bit m_off, m_arm, m_chg;
  int q_fn[$], q_rg[$], q_ct[$], q_dp[$];

  function automatic int ref_fn(input int d);
    case (d)
      0: return 0; 7: return 1; 1: return 2; 4: return 3; 3: return 4; 2: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int ref_rg(input int d);
    if (d <= 4) return d;
    return -1;
  endfunction

  function automatic bit has(input int q[$], input int d);
    foreach (q[i]) if (q[i] == d) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_func = 0; m_rng = 0; m_ctl = 0; m_dp = 0;
      m_off = 0; m_arm = 0; m_chg = 0;
      q_fn.delete(); q_rg.delete(); q_ct.delete(); q_dp.delete();
    end else begin
      bit fe, use_it, n_off, n_arm, n_chg;
      int nf, nr;
      fe = smp && (dig == 0);
      if (smp) begin
        if (fn_p) q_fn.push_back(int'(dig));
        if (rg_p) q_rg.push_back(int'(dig));
        if (ct_p) q_ct.push_back(int'(dig));
        if (dp_p) q_dp.push_back(int'(dig));
      end
      use_it = fe && m_arm && !m_off;
      n_off = m_off; n_chg = 0;
      n_arm = m_off ? 0 : (fe ? 1 : m_arm);
      if (use_it) begin
        nf = (q_fn.size() == 1) ? ref_fn(q_fn[0]) : -1;
        nr = (q_rg.size() == 1) ? ref_rg(q_rg[0]) : -1;
        if (nf >= 0 && nf != m_func) begin m_func = nf; n_chg = 1; end
        if (nr >= 0 && nr != m_rng)  begin m_rng = nr;  n_chg = 1; end
        m_ctl = has(q_ct, 0) + 2 * has(q_ct, 1) + 4 * has(q_ct, 2) + 8 * has(q_ct, 7);
        m_dp = 0;
        foreach (q_dp[i]) m_dp = m_dp | (1 << q_dp[i]);
        if (has(q_ct, 3) && hold) n_off = 1;
      end
      if (m_off && !hold) begin n_off = 0; n_chg = 1; end
      if (fe) begin q_fn.delete(); q_rg.delete(); q_ct.delete(); q_dp.delete(); end
      m_off = n_off; m_arm = n_arm; m_chg = n_chg;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(h_func == m_func, "R4 func", h_func, m_func);
      chk(h_rng == m_rng, "R5 range", h_rng, m_rng);
      chk(h_ctl == m_ctl, "R7 ctl", h_ctl, m_ctl);
      chk(h_dp == m_dp, "R11 dpmask", h_dp, m_dp);
      chk(h_off == m_off, "R8 dispoff", h_off, m_off);
      chk(h_chg == m_chg, "R10 chg", h_chg, m_chg);
      chk({l_func, l_rng, l_ctl, l_dp, l_off, l_chg} == {h_func, h_rng, h_ctl, h_dp, h_off, h_chg},
          "R2 polarity", int'(l_func), int'(h_func));
    end
  end

  // ---------------- stimulus ----------------
  task automatic frame(input logic [7:0] fm, input logic [7:0] rm,
                       input logic [7:0] cm, input logic [7:0] dm, input logic hd);
    for (int d = 7; d >= 0; d--) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        hold = hd;
        dig  = 3'(d);
        smp  = (c == 2);
        // R1: the noise cycles carry the complement of the selection
        fn_p = (c == 2) ? fm[d] : ~fm[d];
        rg_p = (c == 2) ? rm[d] : ~rm[d];
        ct_p = (c == 2) ? cm[d] : ~cm[d];
        dp_p = (c == 2) ? dm[d] : ~dm[d];
      end
    end
    @(negedge clk);
    smp = 0;
  endtask

  initial begin : wdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog got=%0d exp=%0d", cycles, 150000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] fmask [6] = '{8'h01, 8'h80, 8'h02, 8'h10, 8'h08, 8'h04};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({h_func, h_rng, h_ctl, h_dp, h_off, h_chg} == '0, "R3 reset", h_func, 0);

    frame(8'h02, 8'h04, 8'h83, 8'h08, 0);
    chk(h_func == 0, "R9 first frame after reset discarded", h_func, 0);
    frame(8'h02, 8'h04, 8'h83, 8'h08, 0);
    chk(h_func == 2, "R4 ratio", h_func, 2);
    chk(h_rng == 2, "R5 range D3", h_rng, 2);
    chk(h_ctl == 4'b1011, "R7 flags", h_ctl, 11);
    chk(h_dp == 8'h08, "R11 dp D4", h_dp, 8);
    chk(h_chg == 1, "R10 pulse on change", h_chg, 1);
    @(negedge clk);
    chk(h_chg == 0, "R10 single cycle", h_chg, 0);
    frame(8'h02, 8'h04, 8'h83, 8'h08, 0);
    chk(h_chg == 0, "R10 no pulse on repeat", h_chg, 0);

    frame(8'h80, 8'h10, 8'h00, 8'h00, 0);
    chk(h_func == 1, "R1 period despite noise", h_func, 1);
    chk(h_rng == 4, "R5 external range", h_rng, 4);

    frame(8'h05, 8'h80, 8'h00, 8'h00, 0);
    chk(h_func == 1, "R6 two strobes kept", h_func, 1);
    chk(h_rng == 4, "R6 D8 range kept", h_rng, 4);
    frame(8'h40, 8'h20, 8'h00, 8'h00, 0);
    chk(h_func == 1, "R6 D7 kept", h_func, 1);
    frame(8'h00, 8'h00, 8'h00, 8'h00, 0);
    chk(h_func == 1, "R6 none kept", h_func, 1);

    for (int k = 0; k < 6; k++) begin
      frame(fmask[k], 8'h01 << (k % 5), 8'h00, 8'h00, 0);
      chk(h_func == 3'(k), "R4 code sweep", h_func, k);
      chk(h_rng == 3'(k % 5), "R5 code sweep", h_rng, k % 5);
    end

    frame(8'h01, 8'h01, 8'h08, 8'h00, 1);
    chk(h_off == 1, "R8 display off set", h_off, 1);
    frame(8'h04, 8'h02, 8'h00, 8'h00, 1);
    chk(h_func == 0, "R9 ignored while off", h_func, 0);
    chk(h_off == 1, "R8 stays off", h_off, 1);
    @(negedge clk);
    hold = 0;
    @(negedge clk);
    chk(h_off == 0, "R8 hold release", h_off, 0);
    chk(h_chg == 1, "R10 restart pulse", h_chg, 1);
    frame(8'h04, 8'h01, 8'h00, 8'h00, 0);
    chk(h_func == 0, "R9 first frame after off discarded", h_func, 0);
    frame(8'h04, 8'h01, 8'h00, 8'h00, 0);
    chk(h_func == 5, "R4 self-test", h_func, 5);
    frame(8'h04, 8'h01, 8'h08, 8'h00, 0);
    chk(h_off == 0, "R8 D4 without hold", h_off, 0);
    chk(l_func == h_func, "R2 variants agree", l_func, h_func);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule